// File: doc/BRIEF.md
# Strided IDE Register Window Decoder

This block sits between a simple memory-mapped bus and an IDE task-file port. It occupies a 4 KiB window in which each device register lies 16 bytes from the next, so the register index is address bits [11:4]. Single-byte accesses reach the command-block registers and the control/alternate-status register, which answers at two aliased indices. Halfword and word accesses reach only the data port at index 0, with their byte order reversed in both directions. Any other access is unmapped: a read returns all ones at the width of the access, and a write is dropped. The drive behind the task-file port is outside this block.

An access begins when `req_valid` is high while the controller is idle. The downstream strobe is driven in that same cycle, and the read data that comes back is registered. The response therefore appears on `rsp_valid`/`rsp_rdata` one cycle later. The controller is a three-state machine. `ST_IDLE` accepts an access and moves to `ST_RESPOND` (transition "accept"). `ST_RESPOND` drives the one-cycle response, then goes back to `ST_IDLE` if the strobe has dropped ("release") or on to `ST_HOLD` if it is still high ("extend"). `ST_HOLD` waits for the strobe to fall and then returns to `ST_IDLE` ("drop"). A strobe held for several cycles therefore produces one downstream access, and the drive's data FIFO is never popped twice.

Top module: `ide_window_bridge`

## Requirements
- R1: The register index is `req_addr[11:4]`. Address bits above bit 11 and below bit 4 have no effect on decoding.
- R2: A byte access (`req_size` = 2'b00) at index 1 to 7 drives `tf_reg` equal to the index. A byte read returns `tf_rdata[7:0]` zero-extended to 32 bits.
- R3: A byte access at index 8 or index 22 drives `tf_reg` = 8, which is device control on a write and alternate status on a read.
- R4: A byte access at any other index, index 0 included, raises no downstream strobe. A read of this kind returns 32'h0000_00FF.
- R5: A halfword access (`req_size` = 2'b01) at index 0 drives `tf_reg` = 0 and `tf_size` = 2'b01. The two bytes are swapped: the write data becomes {16'h0, wdata[7:0], wdata[15:8]}, and the read data is {16'h0, tf_rdata[7:0], tf_rdata[15:8]}.
- R6: A word access (`req_size` = 2'b10) at index 0 drives `tf_reg` = 0 and `tf_size` = 2'b10, with all four bytes reversed in both directions.
- R7: A halfword or word access at a non-zero index raises no strobe, and neither does any access with `req_size` = 2'b11. Reads of this kind return 32'h0000_FFFF for a halfword and 32'hFFFF_FFFF otherwise.
- R8: `rsp_valid` pulses for exactly one cycle, in the cycle after the access is accepted. A write response carries `rsp_rdata` = 0.
- R9: Each access raises at most one `tf_rd` or `tf_wr` pulse, however long `req_valid` is held. A new access needs `req_valid` to be low for at least one cycle first.
- R10: After reset, `rsp_valid` is 0, `rsp_rdata` is 0 and no downstream strobe is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Access strobe |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 32 | Byte address |
| req_size | input | 2 | 00 byte, 01 halfword, 10 word |
| req_wdata | input | 32 | Write data, right-aligned |
| rsp_valid | output | 1 | Response pulse |
| rsp_rdata | output | 32 | Read result |
| tf_reg | output | 4 | Target: 0 data, 1-7 command block, 8 control/alt status |
| tf_size | output | 2 | Access width presented to the task-file |
| tf_rd | output | 1 | Task-file read strobe |
| tf_wr | output | 1 | Task-file write strobe |
| tf_wdata | output | 32 | Task-file write data, already swapped |
| tf_rdata | input | 32 | Task-file read data, same cycle as `tf_rd` |

## Verification
Two functions can fall in the same cycle: the response to an accepted access, and a strobe that is still held high after that acceptance. The bench provokes the overlap by holding `req_valid` high for several cycles on a data-port read. It then judges the result by counting `tf_rd` pulses, which must be exactly one, and `rsp_valid` pulses, which must also be one. As a second check it confirms that a following access is accepted normally.

// File: rtl/ide_win_pkg.sv
package ide_win_pkg;
    typedef enum logic [1:0] {
        SZ_BYTE = 2'b00,
        SZ_HALF = 2'b01,
        SZ_WORD = 2'b10,
        SZ_BAD  = 2'b11
    } acc_size_e;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_RESPOND = 2'd1,
        ST_HOLD    = 2'd2
    } win_state_e;

    localparam logic [3:0] TGT_DATA = 4'd0;
    localparam logic [3:0] TGT_CTRL = 4'd8;

    typedef struct packed {
        logic       mapped;
        logic [3:0] tgt;
    } win_decode_t;
endpackage

// File: rtl/ide_win_decode.sv
module ide_win_decode
    import ide_win_pkg::*;
#(
    parameter int IDX_W   = 8,
    parameter int ALIAS_A = 8,
    parameter int ALIAS_B = 22,
    parameter int CMD_MAX = 7
) (
    input  logic [IDX_W-1:0] idx,
    input  logic [1:0]       size,
    output win_decode_t      dec
);
    always_comb begin
        dec = '{mapped: 1'b0, tgt: TGT_DATA};
        unique case (size)
            SZ_BYTE: begin
                if (idx >= IDX_W'(1) && idx <= IDX_W'(CMD_MAX)) begin
                    dec.mapped = 1'b1;
                    dec.tgt    = idx[3:0];
                end else if (idx == IDX_W'(ALIAS_A) || idx == IDX_W'(ALIAS_B)) begin
                    dec.mapped = 1'b1;
                    dec.tgt    = TGT_CTRL;
                end
            end
            SZ_HALF, SZ_WORD: begin
                if (idx == '0) begin
                    dec.mapped = 1'b1;
                    dec.tgt    = TGT_DATA;
                end
            end
            default: dec.mapped = 1'b0;
        endcase
    end
endmodule

// File: rtl/ide_win_swap.sv
module ide_win_swap
    import ide_win_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [1:0]        size,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout
);
    localparam int NBYTES = DATA_W / 8;

    logic [DATA_W-1:0] rev_word;

    for (genvar b = 0; b < NBYTES; b++) begin : g_rev
        assign rev_word[b*8 +: 8] = din[(NBYTES-1-b)*8 +: 8];
    end

    always_comb begin
        dout = '0;
        unique case (size)
            SZ_BYTE: dout[7:0]  = din[7:0];
            SZ_HALF: dout[15:0] = {din[7:0], din[15:8]};
            SZ_WORD: dout       = rev_word;
            default: dout       = '0;
        endcase
    end
endmodule

// File: rtl/ide_window_bridge.sv
module ide_window_bridge
    import ide_win_pkg::*;
#(
    parameter int ADDR_W      = 32,
    parameter int DATA_W      = 32,
    parameter int WIN_BITS    = 12,
    parameter int STRIDE_BITS = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_we,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [1:0]        req_size,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic [3:0]        tf_reg,
    output logic [1:0]        tf_size,
    output logic              tf_rd,
    output logic              tf_wr,
    output logic [DATA_W-1:0] tf_wdata,
    input  logic [DATA_W-1:0] tf_rdata
);
    localparam int IDX_W = WIN_BITS - STRIDE_BITS;

    win_state_e        state, state_nx;
    win_decode_t       dec;
    logic [IDX_W-1:0]  idx;
    logic [DATA_W-1:0] rd_swapped;
    logic [DATA_W-1:0] rd_next;
    logic              accept;

    assign idx    = req_addr[WIN_BITS-1:STRIDE_BITS];
    assign accept = (state == ST_IDLE) && req_valid;

    ide_win_decode #(.IDX_W(IDX_W)) u_decode (
        .idx  (idx),
        .size (req_size),
        .dec  (dec)
    );

    ide_win_swap #(.DATA_W(DATA_W)) u_wswap (
        .size (req_size),
        .din  (req_wdata),
        .dout (tf_wdata)
    );

    ide_win_swap #(.DATA_W(DATA_W)) u_rswap (
        .size (req_size),
        .din  (tf_rdata),
        .dout (rd_swapped)
    );

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:    if (req_valid) state_nx = ST_RESPOND;
            ST_RESPOND: state_nx = req_valid ? ST_HOLD : ST_IDLE;
            ST_HOLD:    if (!req_valid) state_nx = ST_IDLE;
            default:    state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        tf_reg  = dec.tgt;
        tf_size = req_size;
        tf_rd   = accept && !req_we && dec.mapped;
        tf_wr   = accept &&  req_we && dec.mapped;
        if (req_we) begin
            rd_next = '0;
        end else if (dec.mapped) begin
            rd_next = rd_swapped;
        end else begin
            unique case (req_size)
                SZ_BYTE: rd_next = DATA_W'(8'hFF);
                SZ_HALF: rd_next = DATA_W'(16'hFFFF);
                default: rd_next = '1;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= accept;
            if (accept) rsp_rdata <= rd_next;
        end
    end

    // R9: a single data-port pop per access
    a_r9_single_rd: assert property (@(posedge clk) disable iff (!rst_n)
        tf_rd |=> !tf_rd);
    a_r9_single_wr: assert property (@(posedge clk) disable iff (!rst_n)
        tf_wr |=> !tf_wr);
    // R8: response follows acceptance and lasts one cycle
    a_r8_rsp_follows: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && req_valid) |=> rsp_valid);
    a_r8_rsp_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);
    // R4: byte read above the alias range gives 0xFF
    a_r4_byte_default: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !req_we && req_size == 2'b00 && idx > IDX_W'(22))
        |=> rsp_rdata == DATA_W'(8'hFF));
    // R3: strobes never name a target above the control register
    a_r3_target_range: assert property (@(posedge clk) disable iff (!rst_n)
        (tf_rd || tf_wr) |-> tf_reg <= 4'd8);
endmodule

// File: tb/test_ide_window_bridge.sv
module test_ide_window_bridge;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid, req_we;
    logic [31:0] req_addr, req_wdata;
    logic [1:0]  req_size;
    logic        rsp_valid;
    logic [31:0] rsp_rdata;
    logic [3:0]  tf_reg;
    logic [1:0]  tf_size;
    logic        tf_rd, tf_wr;
    logic [31:0] tf_wdata, tf_rdata;

    int checks = 0, fails = 0;
    int rd_cnt = 0, wr_cnt = 0, rsp_cnt = 0;
    logic [3:0]  last_reg;
    logic [1:0]  last_size;
    logic [31:0] last_wdata;
    logic [31:0] got;

    always #2 clk = ~clk;

    ide_window_bridge i_ide_window_bridge (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_we(req_we),
        .req_addr(req_addr), .req_size(req_size), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .tf_reg(tf_reg),
        .tf_size(tf_size), .tf_rd(tf_rd), .tf_wr(tf_wr),
        .tf_wdata(tf_wdata), .tf_rdata(tf_rdata)
    );

    assign tf_rdata = (tf_reg == 4'd0) ? 32'h1122_3344 : {24'h0, 4'hA, tf_reg};

    always @(posedge clk) begin
        if (tf_rd) begin
            rd_cnt <= rd_cnt + 1;
            last_reg <= tf_reg;
            last_size <= tf_size;
        end
        if (tf_wr) begin
            wr_cnt <= wr_cnt + 1;
            last_reg <= tf_reg;
            last_size <= tf_size;
            last_wdata <= tf_wdata;
        end
        if (rsp_valid) rsp_cnt <= rsp_cnt + 1;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic access(input logic we, input logic [31:0] addr, input logic [1:0] sz,
                          input logic [31:0] wd, input int hold, output logic [31:0] rd);
        @(negedge clk);
        req_valid = 1'b1; req_we = we; req_addr = addr; req_size = sz; req_wdata = wd;
        @(negedge clk);
        rd = rsp_rdata;
        chk("R8 rsp_valid", {31'h0, rsp_valid}, 32'h1);
        for (int i = 1; i < hold; i++) begin
            @(negedge clk);
            chk("R8 single pulse", {31'h0, rsp_valid}, 32'h0);
        end
        req_valid = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_reset();
        chk("R10 rsp_valid", {31'h0, rsp_valid}, 32'h0);
        chk("R10 rsp_rdata", rsp_rdata, 32'h0);
        chk("R10 strobes", {30'h0, tf_rd, tf_wr}, 32'h0);
    endtask

    task automatic t_byte_regs();
        int r0;
        r0 = rd_cnt;
        access(1'b0, 32'h0000_0030, 2'b00, 0, 1, got);
        chk("R2 byte read", got, 32'h0000_00A3);
        chk("R2 target", {28'h0, last_reg}, 32'd3);
        access(1'b0, 32'hABCD_E03C, 2'b00, 0, 1, got);
        chk("R1 upper bits ignored", got, 32'h0000_00A3);
        access(1'b0, 32'h0000_0080, 2'b00, 0, 1, got);
        chk("R3 alt status idx8", got, 32'h0000_00A8);
        access(1'b0, 32'h0000_0160, 2'b00, 0, 1, got);
        chk("R3 alt status idx22", got, 32'h0000_00A8);
        chk("R2 R3 rd pulses", rd_cnt - r0, 4);
        access(1'b1, 32'h0000_0050, 2'b00, 32'hFFFF_FF5A, 1, got);
        chk("R2 write target", {28'h0, last_reg}, 32'd5);
        chk("R2 write data", last_wdata, 32'h0000_005A);
        chk("R8 write rdata", got, 32'h0);
        access(1'b1, 32'h0000_0164, 2'b00, 32'h04, 1, got);
        chk("R3 control write", {28'h0, last_reg}, 32'd8);
    endtask

    task automatic t_unmapped();
        int r0, w0;
        r0 = rd_cnt; w0 = wr_cnt;
        access(1'b0, 32'h0000_0000, 2'b00, 0, 1, got);
        chk("R4 byte idx0", got, 32'h0000_00FF);
        access(1'b0, 32'h0000_0090, 2'b00, 0, 1, got);
        chk("R4 byte idx9", got, 32'h0000_00FF);
        access(1'b0, 32'h0000_0FF0, 2'b00, 0, 1, got);
        chk("R4 byte idx255", got, 32'h0000_00FF);
        access(1'b0, 32'h0000_0010, 2'b01, 0, 1, got);
        chk("R7 half idx1", got, 32'h0000_FFFF);
        access(1'b0, 32'h0000_0020, 2'b10, 0, 1, got);
        chk("R7 word idx2", got, 32'hFFFF_FFFF);
        access(1'b0, 32'h0000_0000, 2'b11, 0, 1, got);
        chk("R7 bad size", got, 32'hFFFF_FFFF);
        access(1'b1, 32'h0000_00A0, 2'b00, 32'h77, 1, got);
        access(1'b1, 32'h0000_0030, 2'b01, 32'h1234, 1, got);
        chk("R4 R7 no rd strobe", rd_cnt - r0, 0);
        chk("R4 R7 write dropped", wr_cnt - w0, 0);
    endtask

    task automatic t_data_port();
        access(1'b0, 32'h0000_0000, 2'b01, 0, 1, got);
        chk("R5 half read swap", got, 32'h0000_4433);
        chk("R5 tf_size", {30'h0, last_size}, 32'd1);
        access(1'b0, 32'h0000_000C, 2'b10, 0, 1, got);
        chk("R6 word read swap", got, 32'h4433_2211);
        chk("R6 tf_size", {30'h0, last_size}, 32'd2);
        access(1'b1, 32'h0000_0000, 2'b01, 32'h0000_BEEF, 1, got);
        chk("R5 half write swap", last_wdata, 32'h0000_EFBE);
        access(1'b1, 32'h0000_0000, 2'b10, 32'h1234_5678, 1, got);
        chk("R6 word write swap", last_wdata, 32'h7856_3412);
    endtask

    task automatic t_held_strobe();
        int r0, p0;
        r0 = rd_cnt; p0 = rsp_cnt;
        access(1'b0, 32'h0000_0000, 2'b10, 0, 4, got);
        chk("R9 held read value", got, 32'h4433_2211);
        chk("R9 one pop", rd_cnt - r0, 1);
        chk("R9 one response", rsp_cnt - p0, 1);
        access(1'b0, 32'h0000_0070, 2'b00, 0, 1, got);
        chk("R9 next access", got, 32'h0000_00A7);
    endtask

    initial begin
        #(200000 * 4);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        rst_n = 1'b0; req_valid = 1'b0; req_we = 1'b0;
        req_addr = '0; req_size = '0; req_wdata = '0;
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_byte_regs();
        t_unmapped();
        t_data_port();
        t_held_strobe();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule